// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block sits next to a real-time clock and controls the power state of the rest of the chip. Software writes a command word to request hibernation. The block then drops the system power-enable output and waits on an active-low wakeup pin. A wakeup counts only after the pin has stayed low for a programmed number of reference ticks. The block then turns power back on and holds an active-low system reset low for a second programmed number of ticks.

The wakeup pin passes through a synchronizer before it reaches the filter. The filter and the reset stretch both count only on cycles where the `tick` enable is high. Each of the two timing settings is taken from a bit field of a register write, and the low bits of the field are forced to zero, so both timings come in steps of 32 ticks.

Top module: `hib_wake_seq`

## Requirements
- R1: After `rst_n` is released, `pwr_en` is 1 and `sys_rst_n` is 1. The wakeup filter setting F and the reset stretch setting R are both 0.
- R2: A write to offset 0x20 with data bit 0 set, while the block is running, drives `pwr_en` to 0 on the next clock. A write to 0x20 with bit 0 clear has no effect. A write to any other offset never starts hibernation.
- R3: A write to offset 0x24 sets F = data & 0xFFE0 ticks. Data bits outside 15:5 are ignored.
- R4: A write to offset 0x28 sets R = data & 0xFE0 ticks. Data bits outside 11:5 are ignored.
- R5: While hibernating, a low pulse on `wake_n` wakes the system only if the synchronized pin is sampled low on F+2 consecutive ticks. With `tick` high every cycle, this means a pulse of at least F+2 clocks. A shorter pulse is ignored, `pwr_en` stays 0, and the count starts over.
- R6: With `tick` high every cycle, `pwr_en` rises on the (F+4)-th rising clock edge after `wake_n` falls. Two of those edges are the synchronizer.
- R7: When power returns, `sys_rst_n` goes low on that same edge. It stays low for max(R,1) ticks and then returns to 1. `pwr_en` stays 1 the whole time.
- R8: `wake_n` has no effect while the system is running or in the reset stretch.
- R9: A hibernate write that arrives while the block is not running is ignored. This includes the clock edge on which the reset stretch ends.
- R10: While `tick` is 0, the filter and the stretch do not advance. A held-low `wake_n` with no ticks leaves `pwr_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Reference tick enable; the counters advance only when it is high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Register write data |
| wake_n | input | 1 | Active-low wakeup pin, asynchronous |
| pwr_en | output | 1 | System power enable |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
Two events can land on the same clock edge: the reset stretch counter reaching its limit, and a software hibernate request. The bench lines up a hibernate write so that it is captured on exactly the edge where `sys_rst_n` returns high. It then requires `pwr_en` to stay 1 and the block to keep running. A second case does the same at the filter boundary: random pulses of F+1 and F+2 ticks decide whether a wakeup is accepted, and the bench judges each outcome from the pulse length alone.

// File: rtl/hib_pkg.sv
package hib_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HIB  = 2'd1,
        ST_FILT = 2'd2,
        ST_RST  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/hib_cfg_regs.sv
module hib_cfg_regs #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int FLT_LSB = 5,
    parameter int FLT_MSB = 15,
    parameter int RST_LSB = 5,
    parameter int RST_MSB = 11,
    parameter logic [ADDR_W-1:0] HIB_OFS = 8'h20,
    parameter logic [ADDR_W-1:0] FLT_OFS = 8'h24,
    parameter logic [ADDR_W-1:0] RST_OFS = 8'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hib_req,
    output logic [FLT_MSB:0]  flt_ticks,
    output logic [RST_MSB:0]  rst_ticks
);
    localparam int FLT_FW = FLT_MSB - FLT_LSB + 1;
    localparam int RST_FW = RST_MSB - RST_LSB + 1;

    typedef struct packed {
        logic [FLT_FW-1:0] flt;
        logic [RST_FW-1:0] rst;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_bits;

    assign unused_bits = ^wr_data;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && wr_addr == FLT_OFS) cfg_d.flt = wr_data[FLT_MSB:FLT_LSB];
        if (wr_en && wr_addr == RST_OFS) cfg_d.rst = wr_data[RST_MSB:RST_LSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign hib_req   = wr_en && (wr_addr == HIB_OFS) && wr_data[0];
    assign flt_ticks = {cfg_q.flt, {FLT_LSB{1'b0}}};
    assign rst_ticks = {cfg_q.rst, {RST_LSB{1'b0}}};

    assert_flt_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == FLT_OFS) |=> flt_ticks[FLT_MSB:FLT_LSB] == $past(wr_data[FLT_MSB:FLT_LSB]));

    assert_rst_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RST_OFS) |=> rst_ticks[RST_MSB:RST_LSB] == $past(wr_data[RST_MSB:RST_LSB]));

endmodule

// File: rtl/hib_pin_sync.sv
module hib_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pin_async;
        for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign pin_sync = chain_q[STAGES-1];

    generate
        if (STAGES > 1) begin : g_chk
            assert_sync_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(chain_q[0]) |=> !chain_q[1]);
        end
    endgenerate

endmodule

// File: rtl/hib_seq_fsm.sv
module hib_seq_fsm
    import hib_pkg::*;
#(
    parameter int FLT_W = 16,
    parameter int RST_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hib_req,
    input  logic             wake_n_sync,
    input  logic [FLT_W-1:0] flt_ticks,
    input  logic [RST_W-1:0] rst_ticks,
    output logic             pwr_en,
    output logic             sys_rst_n
);
    typedef struct packed {
        seq_state_e       st;
        logic [FLT_W-1:0] fcnt;
        logic [RST_W-1:0] rcnt;
    } seq_t;

    seq_t        s_d, s_q;
    logic [RST_W:0] rinc;

    always_comb begin
        s_d  = s_q;
        rinc = {1'b0, s_q.rcnt} + {{RST_W{1'b0}}, 1'b1};
        case (s_q.st)
            ST_RUN: begin
                if (hib_req) begin
                    s_d.st   = ST_HIB;
                    s_d.fcnt = '0;
                end
            end
            ST_HIB: begin
                if (tick && !wake_n_sync) begin
                    s_d.st   = ST_FILT;
                    s_d.fcnt = '0;
                end
            end
            ST_FILT: begin
                if (tick) begin
                    if (wake_n_sync) begin
                        s_d.st   = ST_HIB;
                        s_d.fcnt = '0;
                    end else if (s_q.fcnt >= flt_ticks) begin
                        s_d.st   = ST_RST;
                        s_d.rcnt = '0;
                    end else begin
                        s_d.fcnt = s_q.fcnt + 1'b1;
                    end
                end
            end
            ST_RST: begin
                if (tick) begin
                    if (rinc >= {1'b0, rst_ticks}) s_d.st = ST_RUN;
                    else                           s_d.rcnt = rinc[RST_W-1:0];
                end
            end
            default: s_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_RUN, fcnt: '0, rcnt: '0};
        else        s_q <= s_d;
    end

    assign pwr_en    = (s_q.st == ST_RUN) || (s_q.st == ST_RST);
    assign sys_rst_n = (s_q.st != ST_RST);

    assert_hib_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hib_req && pwr_en && sys_rst_n) |=> !pwr_en);

    assert_pin_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && !hib_req) |=> pwr_en);

    assert_reset_powered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |-> pwr_en);

    assert_power_up_in_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> !sys_rst_n);

    assert_no_tick_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && s_q.st != ST_RUN) |=> $stable(s_q.st));

    assert_late_hib_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hib_req && !sys_rst_n) |=> pwr_en);

endmodule

// File: rtl/hib_wake_seq.sv
module hib_wake_seq #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int FLT_LSB     = 5,
    parameter int FLT_MSB     = 15,
    parameter int RST_LSB     = 5,
    parameter int RST_MSB     = 11,
    parameter int SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] HIB_OFS = 8'h20,
    parameter logic [ADDR_W-1:0] FLT_OFS = 8'h24,
    parameter logic [ADDR_W-1:0] RST_OFS = 8'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wake_n,
    output logic              pwr_en,
    output logic              sys_rst_n
);
    localparam int FLT_W = FLT_MSB + 1;
    localparam int RST_W = RST_MSB + 1;

    logic             hib_req;
    logic             wake_n_sync;
    logic [FLT_W-1:0] flt_ticks;
    logic [RST_W-1:0] rst_ticks;

    hib_cfg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .FLT_LSB(FLT_LSB), .FLT_MSB(FLT_MSB),
        .RST_LSB(RST_LSB), .RST_MSB(RST_MSB),
        .HIB_OFS(HIB_OFS), .FLT_OFS(FLT_OFS), .RST_OFS(RST_OFS)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hib_req(hib_req),
        .flt_ticks(flt_ticks), .rst_ticks(rst_ticks)
    );

    hib_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(wake_n), .pin_sync(wake_n_sync)
    );

    hib_seq_fsm #(.FLT_W(FLT_W), .RST_W(RST_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hib_req(hib_req),
        .wake_n_sync(wake_n_sync), .flt_ticks(flt_ticks), .rst_ticks(rst_ticks),
        .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
    );

endmodule

// File: tb/tb_hib_wake_seq.sv
module tb_hib_wake_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wake_n = 1'b1;
    logic        pwr_en, sys_rst_n;

    int n_chk = 0;
    int n_fail = 0;
    int cur_f = 0;
    int cur_r = 0;

    always #5 clk = ~clk;

    hib_wake_seq dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wake_n(wake_n), .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
    );

    function automatic int exp_flt(input logic [31:0] d); return int'(d & 32'h0000_FFE0); endfunction
    function automatic int exp_rst(input logic [31:0] d); return int'(d & 32'h0000_0FE0); endfunction
    function automatic int exp_low(input int r); return (r < 1) ? 1 : r; endfunction
    function automatic bit exp_wake(input int len, input int f); return len >= f + 2; endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic set_cfg(input logic [31:0] fd, input logic [31:0] rd);
        wr(8'h24, fd); cur_f = exp_flt(fd);
        wr(8'h28, rd); cur_r = exp_rst(rd);
    endtask

    task automatic go_hib();
        wr(8'h20, 32'h1 | ($urandom & 32'hFFFF_FFFE));
        chk(pwr_en == 1'b0, "R2 hibernate entry", pwr_en, 0);
    endtask

    // hold wake_n low until power returns; measure rise latency and reset width
    task automatic wake_measure(input bit collide);
        int k = 0;
        int n = 0;
        wake_n = 1'b0;
        do begin
            @(negedge clk); k++;
        end while (!pwr_en && k < cur_f + 50);
        chk(k == cur_f + 4, "R6 wake latency", k, cur_f + 4);
        while (!sys_rst_n && n < cur_r + 50) begin
            n++;
            if (collide && n == exp_low(cur_r)) begin
                wr_en = 1'b1; wr_addr = 8'h20; wr_data = 32'h1;
            end
            @(negedge clk);
            wr_en = 1'b0;
            if (!pwr_en) break;
        end
        chk(n == exp_low(cur_r), "R7 reset low width", n, exp_low(cur_r));
        chk(pwr_en == 1'b1 && sys_rst_n == 1'b1, "R7/R9 running after stretch", {pwr_en, sys_rst_n}, 3);
        repeat (3) @(negedge clk);
        chk(pwr_en == 1'b1, "R8 pin low while running", pwr_en, 1);
        wake_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4177));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pwr_en == 1'b1 && sys_rst_n == 1'b1, "R1 reset outputs", {pwr_en, sys_rst_n}, 3);

        // R1: defaults F=0, R=0 observed through timing
        go_hib();
        wake_measure(1'b0);

        // R2: bit0 clear and wrong offset do nothing
        wr(8'h20, 32'hFFFF_FFFE);
        @(negedge clk);
        chk(pwr_en == 1'b1, "R2 bit0 clear ignored", pwr_en, 1);
        wr(8'h2C, 32'h1);
        @(negedge clk);
        chk(pwr_en == 1'b1, "R2 other offset ignored", pwr_en, 1);

        // R3/R4: junk bits outside the fields
        set_cfg(32'hABCD_0037, 32'h5A5A_F05F);
        go_hib();
        wake_measure(1'b0);

        // R5: directed boundary with F=32
        set_cfg(32'hFFFF_003F, 32'h0000_0020);
        go_hib();
        wake_n = 1'b0; repeat (cur_f + 1) @(negedge clk); wake_n = 1'b1;
        repeat (cur_f + 10) @(negedge clk);
        chk(pwr_en == 1'b0, "R5 short pulse ignored", pwr_en, 0);
        wake_n = 1'b0; repeat (cur_f + 2) @(negedge clk); wake_n = 1'b1;
        repeat (cur_f + 10) @(negedge clk);
        chk(pwr_en == 1'b1, "R5 minimum pulse accepted", pwr_en, 1);
        repeat (cur_r + 5) @(negedge clk);

        // R10: no ticks, no progress
        go_hib();
        tick = 1'b0;
        wake_n = 1'b0;
        repeat (cur_f + 60) @(negedge clk);
        chk(pwr_en == 1'b0, "R10 frozen without tick", pwr_en, 0);
        wake_n = 1'b1;
        tick = 1'b1;
        repeat (5) @(negedge clk);
        chk(pwr_en == 1'b0, "R10 still hibernating", pwr_en, 0);
        wake_measure(1'b0);

        // R9: hibernate write on the edge the stretch ends, and mid-stretch
        set_cfg(32'h0000_0040, 32'h0000_0060);
        go_hib();
        wake_measure(1'b1);
        @(negedge clk);
        chk(pwr_en == 1'b1, "R9 same-edge hibernate ignored", pwr_en, 1);
        go_hib();
        wake_n = 1'b0;
        repeat (cur_f + 4) @(negedge clk);
        wake_n = 1'b1;
        wr(8'h20, 32'h1);
        chk(pwr_en == 1'b1 && sys_rst_n == 1'b0, "R9 mid-stretch hibernate ignored", {pwr_en, sys_rst_n}, 2);
        repeat (cur_r + 5) @(negedge clk);
        chk(pwr_en == 1'b1 && sys_rst_n == 1'b1, "R9 stretch completes", {pwr_en, sys_rst_n}, 3);

        // large R4 field value
        set_cfg(32'h0000_0000, 32'hFFFF_FFFF);
        go_hib();
        wake_measure(1'b0);

        // random pulses around the filter threshold (R5)
        for (int it = 0; it < 40; it++) begin
            int len;
            set_cfg(($urandom_range(0, 3) << 5) | ($urandom & 32'hFFFF_001F),
                    ($urandom_range(0, 3) << 5) | ($urandom & 32'hFFFF_F01F));
            go_hib();
            len = $urandom_range(1, cur_f + 6);
            wake_n = 1'b0; repeat (len) @(negedge clk); wake_n = 1'b1;
            repeat (cur_f + 10) @(negedge clk);
            chk(pwr_en == exp_wake(len, cur_f), "R5 random pulse", pwr_en, exp_wake(len, cur_f));
            if (pwr_en) begin
                repeat (cur_r + 5) @(negedge clk);
                chk(sys_rst_n == 1'b1, "R7 random stretch done", sys_rst_n, 1);
            end else begin
                wake_measure(1'b0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule